// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Collector

This block gathers 64 interrupt request lines into a single interrupt output for a processor. Each source has a two-bit priority level, an enable and a software-trigger bit. Among pending and enabled sources, the one with the highest level wins. If two winning sources share a level, the lower source number wins. The block tracks which levels are currently being serviced. It can let a higher level interrupt a lower one (nesting), or it can block all new requests while any level is in service.

Software reads a vector address. This address is a programmable table base plus four times the winning source number. Software marks the interrupt as entered in one of two ways, chosen by a mode bit: by writing the vector register, or as a side effect of reading it. At the end of the service routine, software writes a level-acknowledge register to end service for that level.

The register interface is a simple 32-bit bus. Each register has four alias addresses: plain write, OR-set, clear, and toggle.

A two-state machine controls the output. In `ST_IDLE` the output is low, and the vector and status registers follow the live winner. The transition `raise` moves to `ST_SIGNAL` when an eligible request exists. In `ST_SIGNAL` the output is high and the selected source is held. Two transitions leave `ST_SIGNAL` and return to `ST_IDLE`:
- `enter` is taken when the chosen entry access marks the held level in service.
- `withdraw` is taken when the global enable has been cleared.

Top module: `irq_collector`

## Requirements
- R1: After reset every register reads zero, no level is in service and `irq_out` is low.
- R2: Address bits [3:2] choose the alias: 0 writes the data plainly, 1 ORs it in, 2 clears the set bits, 3 toggles them. All four aliases read the same value.
- R3: Source n is configured in the register at 0x60 + (n/4)*0x10, in the byte starting at bit 8*(n mod 4). In that byte, bits [1:0] are the level, bit 2 is the enable and bit 3 is the software trigger. Bits [7:4] read as zero.
- R4: Registers 0x40 and 0x50 read the unmasked request lines 0–31 and 32–63.
- R5: A source is pending when it is enabled and its line or its software bit is set. The winner has the highest level (3 is highest). Ties go to the lowest source number.
- R6: `irq_out` rises one cycle after an eligible request appears. A request is eligible when control bit 16 is set and either no level is in service, or nesting is allowed (control bit 19 = 0) and the winner's level is above every level in service.
- R7: Register 0x00 reads base + 4*id, where the base is register 0x160 with bits [1:0] reading zero. Register 0x30 reads id in bits [5:0].
- R8: With control bit 18 = 0, only a write to 0x00 enters service. With bit 18 = 1, only a read of 0x00 enters service. Entering service drops `irq_out` and sets the held level's in-service bit.
- R9: Register 0x10 reads one in-service bit per level. Writing 1s to it clears those bits.
- R10: Writing 1s to 0x1D0 or 0x1E0 clears the software bits of sources 0–31 or 32–63, with bit n mod 32 selecting the source. Reading these registers returns those software bits.
- R11: While `irq_out` is high, registers 0x00 and 0x30 stay on the held source. In idle they follow the live winner.
- R12: Register 0x1F0 is a free 32-bit scratch register.
- R13: Clearing control bit 16 while `irq_out` is high lowers it one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 9 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| irq_src | input | 64 | Interrupt request lines |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
Read data is combinational and is sampled in the access cycle. Register writes take effect at the clock edge that ends the access. The state machine reacts at the next edge, so the bench waits two cycles after any stimulus before it samples `irq_out` or status. The one exception is entry into service: it happens at the edge of the entry access itself, so the drop of `irq_out` is checked straight after that access.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    typedef enum logic [1:0] {
        AL_WRITE = 2'd0,
        AL_SET   = 2'd1,
        AL_CLR   = 2'd2,
        AL_TOG   = 2'd3
    } irqc_alias_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_SIGNAL = 1'b1
    } irqc_state_e;

    // register block index = byte address [8:4]
    localparam int IDX_VECTOR  = 0;
    localparam int IDX_LVLACK  = 1;
    localparam int IDX_CTRL    = 2;
    localparam int IDX_STAT    = 3;
    localparam int IDX_RAW0    = 4;
    localparam int IDX_CFG0    = 6;
    localparam int IDX_VBASE   = 22;
    localparam int IDX_CLR0    = 29;
    localparam int IDX_SCRATCH = 31;

    localparam int CTRL_GEN_EN   = 16;
    localparam int CTRL_RSE      = 18;
    localparam int CTRL_NEST_OFF = 19;

    function automatic logic [31:0] alias_apply(irqc_alias_e al,
                                                logic [31:0] old,
                                                logic [31:0] d);
        logic [31:0] r;
        unique case (al)
            AL_WRITE: r = d;
            AL_SET:   r = old | d;
            AL_CLR:   r = old & ~d;
            AL_TOG:   r = old ^ d;
            default:  r = old;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int NSRC  = 64,
    parameter int LVL_W = 2,
    parameter int ID_W  = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bus_sel,
    input  logic                         bus_wr,
    input  logic [8:0]                   bus_addr,
    input  logic [31:0]                  bus_wdata,
    output logic [31:0]                  bus_rdata,
    input  logic [NSRC-1:0]              irq_src,
    input  logic [31:0]                  vec_value,
    input  logic [ID_W-1:0]              cur_id,
    input  logic [(1<<LVL_W)-1:0]        inservice,
    output logic [NSRC-1:0][LVL_W-1:0]   src_prio,
    output logic [NSRC-1:0]              src_en,
    output logic [NSRC-1:0]              src_soft,
    output logic                         gen_en,
    output logic                         nest_off,
    output logic                         rse_mode,
    output logic [31:0]                  vbase,
    output logic                         vec_wr,
    output logic                         vec_rd,
    output logic                         lvlack_wr,
    output logic [(1<<LVL_W)-1:0]        lvlack_bits
);
    localparam int NLVL   = 1 << LVL_W;
    localparam int NCFG   = NSRC / 4;
    localparam int NBANK  = NSRC / 32;
    localparam int CFG_IW = $clog2(NCFG);
    localparam logic [31:0] CFG_MASK  = 32'h0F0F_0F0F;
    localparam logic [31:0] CTRL_MASK = (32'd1 << CTRL_GEN_EN) |
                                        (32'd1 << CTRL_RSE) |
                                        (32'd1 << CTRL_NEST_OFF);

    logic [4:0]        idx;
    irqc_alias_e       al;
    logic              wen;
    logic [31:0]       ctrl_q, scratch_q, vbase_q;
    logic [31:0]       cfg_q [NCFG];
    logic [31:0]       cfg_d [NCFG];
    logic [NSRC-1:0]   clr_soft;
    logic [4:0]        cfg_off;
    logic [1:0]        addr_lo_unused;

    assign idx            = bus_addr[8:4];
    assign al             = irqc_alias_e'(bus_addr[3:2]);
    assign addr_lo_unused = bus_addr[1:0];
    assign wen            = bus_sel & bus_wr;

    assign vec_wr      = wen && (idx == 5'(IDX_VECTOR));
    assign vec_rd      = bus_sel && !bus_wr && (idx == 5'(IDX_VECTOR));
    assign lvlack_wr   = wen && (idx == 5'(IDX_LVLACK));
    assign lvlack_bits = bus_wdata[NLVL-1:0];

    assign gen_en   = ctrl_q[CTRL_GEN_EN];
    assign rse_mode = ctrl_q[CTRL_RSE];
    assign nest_off = ctrl_q[CTRL_NEST_OFF];
    assign vbase    = vbase_q;

    // soft-trigger clear strobes from the two clear registers
    always_comb begin
        clr_soft = '0;
        for (int b = 0; b < NBANK; b++) begin
            if (wen && idx == 5'(IDX_CLR0 + b))
                clr_soft[b*32 +: 32] = bus_wdata;
        end
    end

    always_comb begin
        for (int i = 0; i < NCFG; i++) begin
            cfg_d[i] = cfg_q[i];
            if (wen && idx == 5'(IDX_CFG0 + i))
                cfg_d[i] = alias_apply(al, cfg_q[i], bus_wdata) & CFG_MASK;
            for (int k = 0; k < 4; k++) begin
                if (clr_soft[4*i + k])
                    cfg_d[i][8*k + 3] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            scratch_q <= '0;
            vbase_q   <= '0;
            for (int i = 0; i < NCFG; i++) cfg_q[i] <= '0;
        end else begin
            for (int i = 0; i < NCFG; i++) cfg_q[i] <= cfg_d[i];
            if (wen && idx == 5'(IDX_CTRL))
                ctrl_q <= alias_apply(al, ctrl_q, bus_wdata) & CTRL_MASK;
            if (wen && idx == 5'(IDX_VBASE))
                vbase_q <= alias_apply(al, vbase_q, bus_wdata) & 32'hFFFF_FFFC;
            if (wen && idx == 5'(IDX_SCRATCH))
                scratch_q <= alias_apply(al, scratch_q, bus_wdata);
        end
    end

    // per-source fields unpacked from the byte lanes
    for (genvar s = 0; s < NSRC; s++) begin : g_src
        assign src_prio[s] = cfg_q[s/4][8*(s%4) +: LVL_W];
        assign src_en[s]   = cfg_q[s/4][8*(s%4) + 2];
        assign src_soft[s] = cfg_q[s/4][8*(s%4) + 3];
    end

    assign cfg_off = idx - 5'(IDX_CFG0);

    always_comb begin
        bus_rdata = '0;
        if (idx == 5'(IDX_VECTOR))       bus_rdata = vec_value;
        else if (idx == 5'(IDX_LVLACK))  bus_rdata = 32'(inservice);
        else if (idx == 5'(IDX_CTRL))    bus_rdata = ctrl_q;
        else if (idx == 5'(IDX_STAT))    bus_rdata = 32'(cur_id);
        else if (idx == 5'(IDX_VBASE))   bus_rdata = vbase_q;
        else if (idx == 5'(IDX_SCRATCH)) bus_rdata = scratch_q;
        else if (idx >= 5'(IDX_CFG0) && idx < 5'(IDX_CFG0 + NCFG))
            bus_rdata = cfg_q[cfg_off[CFG_IW-1:0]];
        for (int b = 0; b < NBANK; b++) begin
            if (idx == 5'(IDX_RAW0 + b)) bus_rdata = irq_src[b*32 +: 32];
            if (idx == 5'(IDX_CLR0 + b)) bus_rdata = src_soft[b*32 +: 32];
        end
    end

endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
    parameter int NSRC  = 64,
    parameter int LVL_W = 2,
    parameter int ID_W  = 6
) (
    input  logic [NSRC-1:0][LVL_W-1:0] src_prio,
    input  logic [NSRC-1:0]            src_en,
    input  logic [NSRC-1:0]            src_soft,
    input  logic [NSRC-1:0]            irq_src,
    output logic                       win_valid,
    output logic [ID_W-1:0]            win_id,
    output logic [LVL_W-1:0]           win_lvl
);
    logic [NSRC-1:0] pend;

    for (genvar i = 0; i < NSRC; i++) begin : g_pend
        assign pend[i] = src_en[i] & (irq_src[i] | src_soft[i]);
    end

    // ascending scan with strict compare: lowest number keeps a tie
    always_comb begin
        win_valid = 1'b0;
        win_id    = '0;
        win_lvl   = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (pend[i] && (!win_valid || src_prio[i] > win_lvl)) begin
                win_valid = 1'b1;
                win_id    = ID_W'(i);
                win_lvl   = src_prio[i];
            end
        end
    end

endmodule

// File: rtl/irqc_fsm.sv
module irqc_fsm
    import irqc_pkg::*;
#(
    parameter int LVL_W = 2,
    parameter int ID_W  = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    win_valid,
    input  logic [ID_W-1:0]         win_id,
    input  logic [LVL_W-1:0]        win_lvl,
    input  logic                    gen_en,
    input  logic                    nest_off,
    input  logic                    rse_mode,
    input  logic                    vec_wr,
    input  logic                    vec_rd,
    input  logic                    lvlack_wr,
    input  logic [(1<<LVL_W)-1:0]   lvlack_bits,
    output logic                    irq_out,
    output logic                    enter,
    output logic [ID_W-1:0]         cur_id,
    output logic [(1<<LVL_W)-1:0]   inservice
);
    localparam int NLVL = 1 << LVL_W;

    irqc_state_e        state_q, state_d;
    logic [ID_W-1:0]    held_id;
    logic [LVL_W-1:0]   held_lvl;
    logic [LVL_W-1:0]   hi_lvl;
    logic               eligible;
    logic [NLVL-1:0]    ack_mask, enter_mask;

    always_comb begin
        hi_lvl = '0;
        for (int l = 0; l < NLVL; l++) begin
            if (inservice[l]) hi_lvl = LVL_W'(l);
        end
    end

    assign eligible = gen_en && win_valid &&
                      ((inservice == '0) || (!nest_off && win_lvl > hi_lvl));

    assign enter = (state_q == ST_SIGNAL) && (rse_mode ? vec_rd : vec_wr);

    // next-state: raise / enter / withdraw
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (eligible) state_d = ST_SIGNAL;
            ST_SIGNAL: if (enter || !gen_en) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register with held selection and in-service levels
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            held_id   <= '0;
            held_lvl  <= '0;
            inservice <= '0;
        end else begin
            state_q   <= state_d;
            inservice <= (inservice & ~ack_mask) | enter_mask;
            if (state_q == ST_IDLE && eligible) begin
                held_id  <= win_id;
                held_lvl <= win_lvl;
            end
        end
    end

    assign ack_mask   = lvlack_wr ? lvlack_bits : '0;
    assign enter_mask = enter ? (NLVL'(1) << held_lvl) : '0;

    // outputs
    always_comb begin
        unique case (state_q)
            ST_SIGNAL: begin
                irq_out = 1'b1;
                cur_id  = held_id;
            end
            default: begin
                irq_out = 1'b0;
                cur_id  = win_valid ? win_id : '0;
            end
        endcase
    end

endmodule

// File: rtl/irq_collector.sv
module irq_collector
    import irqc_pkg::*;
#(
    parameter int NSRC  = 64,
    parameter int LVL_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [8:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NSRC-1:0]   irq_src,
    output logic              irq_out
);
    localparam int ID_W = $clog2(NSRC);
    localparam int NLVL = 1 << LVL_W;

    logic [NSRC-1:0][LVL_W-1:0] src_prio;
    logic [NSRC-1:0]            src_en, src_soft;
    logic                       gen_en, nest_off, rse_mode;
    logic [31:0]                vbase, vec_value;
    logic                       vec_wr, vec_rd, lvlack_wr, enter;
    logic [NLVL-1:0]            lvlack_bits, inservice;
    logic                       win_valid;
    logic [ID_W-1:0]            win_id, cur_id;
    logic [LVL_W-1:0]           win_lvl;

    assign vec_value = {vbase[31:2], 2'b00} + {{(30-ID_W){1'b0}}, cur_id, 2'b00};

    irqc_regs #(.NSRC(NSRC), .LVL_W(LVL_W), .ID_W(ID_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_src(irq_src), .vec_value(vec_value), .cur_id(cur_id),
        .inservice(inservice),
        .src_prio(src_prio), .src_en(src_en), .src_soft(src_soft),
        .gen_en(gen_en), .nest_off(nest_off), .rse_mode(rse_mode),
        .vbase(vbase), .vec_wr(vec_wr), .vec_rd(vec_rd),
        .lvlack_wr(lvlack_wr), .lvlack_bits(lvlack_bits)
    );

    irqc_arbiter #(.NSRC(NSRC), .LVL_W(LVL_W), .ID_W(ID_W)) u_arb (
        .src_prio(src_prio), .src_en(src_en), .src_soft(src_soft),
        .irq_src(irq_src),
        .win_valid(win_valid), .win_id(win_id), .win_lvl(win_lvl)
    );

    irqc_fsm #(.LVL_W(LVL_W), .ID_W(ID_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .win_valid(win_valid), .win_id(win_id), .win_lvl(win_lvl),
        .gen_en(gen_en), .nest_off(nest_off), .rse_mode(rse_mode),
        .vec_wr(vec_wr), .vec_rd(vec_rd),
        .lvlack_wr(lvlack_wr), .lvlack_bits(lvlack_bits),
        .irq_out(irq_out), .enter(enter), .cur_id(cur_id),
        .inservice(inservice)
    );

endmodule

// File: rtl/irq_collector_chk.sv
module irq_collector_chk #(
    parameter int NLVL = 4,
    parameter int ID_W = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            irq_out,
    input logic            gen_en,
    input logic            nest_off,
    input logic            enter,
    input logic            lvlack_wr,
    input logic [NLVL-1:0] lvlack_bits,
    input logic [NLVL-1:0] inservice,
    input logic [ID_W-1:0] cur_id
);

    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_quiet_r1: assert (!irq_out && inservice == '0)
                else $error("irq or in-service set during reset");
        end
    end

    p_gen_enable_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (!gen_en && $past(!gen_en)) |-> !irq_out);

    p_nest_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_out) |-> $past(inservice == '0 || !nest_off));

    p_entry_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && enter) |=> !irq_out);

    p_freeze_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && $past(irq_out)) |-> $stable(cur_id));

    p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (lvlack_wr && !enter) |=> ((inservice & $past(lvlack_bits)) == '0));

endmodule

bind irq_collector irq_collector_chk #(.NLVL(NLVL), .ID_W(ID_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_out(irq_out), .gen_en(gen_en),
    .nest_off(nest_off), .enter(enter), .lvlack_wr(lvlack_wr),
    .lvlack_bits(lvlack_bits), .inservice(inservice), .cur_id(cur_id)
);

// File: tb/irq_collector_tb.sv
module irq_collector_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NTBL = 32;

    // {is_write, addr[8:0], data, expected read, requirement number}
    localparam logic [77:0] TBL [NTBL] = '{
        {1'b0, 9'h000, 32'h0, 32'h0, 4'd1},          // R1
        {1'b0, 9'h010, 32'h0, 32'h0, 4'd1},          // R1
        {1'b0, 9'h020, 32'h0, 32'h0, 4'd1},          // R1
        {1'b0, 9'h030, 32'h0, 32'h0, 4'd1},          // R1
        {1'b0, 9'h060, 32'h0, 32'h0, 4'd1},          // R1
        {1'b0, 9'h160, 32'h0, 32'h0, 4'd1},          // R1
        {1'b0, 9'h1F0, 32'h0, 32'h0, 4'd1},          // R1
        {1'b1, 9'h020, 32'h0001_0000, 32'h0, 4'd2},  // R2 plain
        {1'b0, 9'h020, 32'h0, 32'h0001_0000, 4'd2},
        {1'b1, 9'h024, 32'h0008_0000, 32'h0, 4'd2},  // R2 set
        {1'b0, 9'h02C, 32'h0, 32'h0009_0000, 4'd2},
        {1'b1, 9'h028, 32'h0001_0000, 32'h0, 4'd2},  // R2 clear
        {1'b0, 9'h020, 32'h0, 32'h0008_0000, 4'd2},
        {1'b1, 9'h02C, 32'h0005_0000, 32'h0, 4'd2},  // R2 toggle
        {1'b0, 9'h020, 32'h0, 32'h000D_0000, 4'd2},
        {1'b1, 9'h020, 32'h0, 32'h0, 4'd2},
        {1'b0, 9'h020, 32'h0, 32'h0, 4'd2},
        {1'b1, 9'h060, 32'hFFFF_FFFF, 32'h0, 4'd3},  // R3 upper nibbles zero
        {1'b0, 9'h060, 32'h0, 32'h0F0F_0F0F, 4'd3},
        {1'b1, 9'h06C, 32'h0000_0101, 32'h0, 4'd3},
        {1'b0, 9'h060, 32'h0, 32'h0F0F_0E0E, 4'd3},
        {1'b1, 9'h060, 32'h0, 32'h0, 4'd3},
        {1'b0, 9'h060, 32'h0, 32'h0, 4'd3},
        {1'b1, 9'h160, 32'h1234_5677, 32'h0, 4'd7},  // R7 base low bits
        {1'b0, 9'h160, 32'h0, 32'h1234_5674, 4'd7},
        {1'b1, 9'h1F0, 32'hDEAD_BEEF, 32'h0, 4'd12}, // R12
        {1'b0, 9'h1F0, 32'h0, 32'hDEAD_BEEF, 4'd12},
        {1'b1, 9'h1F4, 32'h0000_0010, 32'h0, 4'd12},
        {1'b0, 9'h1F0, 32'h0, 32'hDEAD_BEFF, 4'd12},
        {1'b1, 9'h1F8, 32'hDEAD_BEFF, 32'h0, 4'd12},
        {1'b0, 9'h1F0, 32'h0, 32'h0, 4'd12},
        {1'b1, 9'h160, 32'h0000_1000, 32'h0, 4'd7}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] irq_src = '0;
    logic        irq_out;
    int          checks = 0, errors = 0;
    logic [31:0] rd;

    irq_collector u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_src(irq_src), .irq_out(irq_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bwr(logic [8:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic brd(logic [8:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic wait2();
        repeat (2) @(negedge clk);
        #1;
    endtask

    task automatic rchk(string req, logic [8:0] a, logic [31:0] exp);
        logic [31:0] v;
        brd(a, v);
        check(req, v, exp);
    endtask

    task automatic irqchk(string req, logic exp);
        #1 check(req, 32'(irq_out), 32'(exp));
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        irqchk("R1", 1'b0);
        rst_n = 1'b1;

        for (int i = 0; i < NTBL; i++) begin
            if (TBL[i][77]) bwr(TBL[i][76:68], TBL[i][67:36]);
            else begin
                brd(TBL[i][76:68], rd);
                check($sformatf("R%0d table row %0d", TBL[i][3:0], i), rd, TBL[i][35:4]);
            end
        end

        // source 5, level 1, enabled; global enable
        bwr(9'h070, 32'h0000_0500);
        bwr(9'h020, 32'h0001_0000);
        irq_src[5] = 1'b1;
        wait2();
        irqchk("R6 raise", 1'b1);
        rchk("R7 status", 9'h030, 32'd5);
        rchk("R7 vector", 9'h000, 32'h0000_1014);
        irqchk("R8 read has no effect in write mode", 1'b1);
        rchk("R8 no entry by read", 9'h010, 32'h0);

        // higher source appears while signalling: stays frozen
        bwr(9'h100, 32'h0000_000F);
        wait2();
        rchk("R11 frozen status", 9'h030, 32'd5);
        bwr(9'h000, 32'h0);
        irqchk("R8 entry drops irq", 1'b0);
        rchk("R9 level 1 in service", 9'h010, 32'h2);
        wait2();
        irqchk("R6 nested raise", 1'b1);
        rchk("R11 status updates", 9'h030, 32'd40);
        rchk("R7 vector 40", 9'h000, 32'h0000_10A0);
        bwr(9'h000, 32'h0);
        rchk("R9 levels 1 and 3", 9'h010, 32'hA);

        // clear register for bank 1
        rchk("R10 soft bits read", 9'h1E0, 32'h0000_0100);
        bwr(9'h1E0, 32'h0000_0100);
        rchk("R10 soft cleared", 9'h1E0, 32'h0);
        rchk("R3 cfg after clear", 9'h100, 32'h0000_0007);

        bwr(9'h010, 32'h8);
        rchk("R9 ack clears level 3", 9'h010, 32'h2);
        wait2();
        irqchk("R6 same level blocked", 1'b0);

        // nesting disabled
        bwr(9'h024, 32'h0008_0000);
        bwr(9'h104, 32'h0000_0008);
        wait2();
        irqchk("R6 nesting off blocks", 1'b0);
        rchk("R11 live winner", 9'h030, 32'd40);
        bwr(9'h010, 32'h2);
        wait2();
        irqchk("R6 raise when idle", 1'b1);

        // read-side-effect mode
        bwr(9'h024, 32'h0004_0000);
        bwr(9'h000, 32'h0);
        irqchk("R8 write ignored in read mode", 1'b1);
        rchk("R8 no entry by write", 9'h010, 32'h0);
        brd(9'h000, rd);
        check("R8 vector read value", rd, 32'h0000_10A0);
        irqchk("R8 read enters", 1'b0);
        rchk("R8 level 3 in service", 9'h010, 32'h8);

        bwr(9'h1E0, 32'h0000_0100);
        wait2();
        rchk("R5 next winner", 9'h030, 32'd5);
        bwr(9'h074, 32'h0000_0005);
        irq_src[4] = 1'b1;
        wait2();
        rchk("R5 tie lowest number", 9'h030, 32'd4);
        bwr(9'h010, 32'h8);
        wait2();
        irqchk("R6 raise source 4", 1'b1);
        rchk("R7 vector 4", 9'h000, 32'h0000_1010);

        bwr(9'h028, 32'h0001_0000);
        wait2();
        irqchk("R13 withdraw", 1'b0);

        rchk("R4 raw low", 9'h040, 32'h0000_0030);
        rchk("R4 raw high", 9'h050, 32'h0);
        irq_src[63] = 1'b1;
        rchk("R4 raw high alias", 9'h05C, 32'h8000_0000);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule